// File: doc/BRIEF.md
# Multicycle Accumulator Processor with Split Memories

This block is a small processor core built around one 16-bit accumulator. A control state machine runs each instruction as a sequence of clock cycles. It reads the instruction stream through a byte-wide instruction-memory port. It reads and writes operands through a separate word-wide data-memory port. Both memory ports use 16-bit addresses. Both are expected to return read data in the same cycle the address is presented, as a register file or a small array does. A 16-bit ALU combines the accumulator with a data word. The ALU reports a negative flag and a zero flag, and these flags are held for conditional branches.

Every instruction is three bytes long: an opcode byte, then the high byte of a 16-bit operand address, then its low byte. The controller states are:

- `ST_INIT`: clears the machine after reset.
- `ST_FETCH_OP`, `ST_FETCH_HI`, `ST_FETCH_LO`: the three fetch cycles.
- `ST_DECODE`: picks the execute path for the instruction.
- `ST_MEM_LOAD`, `ST_MEM_STORE`: the memory class.
- `ST_REG_OP`: accumulator arithmetic and logic.
- `ST_BR_TAKEN`, `ST_BR_SKIP`: the branch class.
- `ST_HALT`: the stopped state.

The transitions are as follows:

- Reset leads to `ST_INIT`.
- `ST_INIT` leads to `ST_FETCH_OP`.
- The fetch states follow one another in order, and `ST_FETCH_LO` leads to `ST_DECODE`.
- `ST_DECODE` branches by opcode:
  - to `ST_MEM_LOAD` or `ST_MEM_STORE`;
  - to `ST_REG_OP` for the four ALU opcodes;
  - to `ST_BR_TAKEN` or `ST_BR_SKIP`, according to the condition and the held flags;
  - to `ST_HALT` for the halt opcode;
  - straight back to `ST_FETCH_OP` for an unrecognised opcode.
- Every execute state returns to `ST_FETCH_OP`.
- `ST_HALT` loops on itself until reset.

Top module: `acc_core`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, the program counter, instruction register, accumulator and both flags read zero and no memory is accessed. The cycle after release is an initialise cycle with `imem_rd` low. The next cycle fetches from address 0.
- R2: An instruction is fetched in three consecutive cycles from `pc_q`, `pc_q+1` and `pc_q+2`: the opcode, then the address high byte, then the address low byte. Each fetch cycle increments the program counter by one. At halt, `pc_q` equals the halt instruction's address plus 3 and `ir_q` holds 0xFF.
- R3: Load, store, ALU and branch instructions take 5 cycles, an unrecognised opcode takes 4, and halt is reached 4 cycles after its fetch begins.
- R4: Opcode 0x01 loads the data word at the operand address into the accumulator. It sets N to bit 15 of the value and Z to whether the value is zero.
- R5: Opcode 0x02 writes the accumulator to the operand address with exactly one data-memory write, and leaves N and Z unchanged.
- R6: Opcodes 0x10 (add, modulo 2^16), 0x11 (accumulator minus memory word), 0x12 (bitwise AND) and 0x13 (bitwise OR) combine the accumulator with the data word at the operand address. The result goes back into the accumulator, and N and Z are set from it.
- R7: Opcode 0x20 always branches, 0x21 branches when Z is set, and 0x22 branches when N is set. A taken branch loads the operand address into the program counter. A branch that is not taken continues at the next instruction. Branches never change the flags or the accumulator.
- R8: Any opcode not listed in R4 to R7 and R9 is a no-op. It only advances the program counter past its three bytes.
- R9: Opcode 0xFF raises `halted` and holds it. From then until reset, the program counter stays fixed and neither memory port is accessed.
- R10: `dmem_rd` and `dmem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Instruction-memory byte address |
| imem_rd | output | 1 | Instruction-memory read strobe |
| imem_rdata | input | 8 | Instruction byte, valid in the same cycle |
| dmem_addr | output | 16 | Data-memory word address |
| dmem_rd | output | 1 | Data-memory read strobe |
| dmem_wr | output | 1 | Data-memory write strobe, written at the clock edge |
| dmem_wdata | output | 16 | Data word to write |
| dmem_rdata | input | 16 | Data word read, valid in the same cycle |
| pc_q | output | 16 | Program counter |
| ir_q | output | 8 | Instruction (opcode) register |
| ac_q | output | 16 | Accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| halted | output | 1 | High while the core is stopped |

## Verification
Some behaviours are checked by the assertions on every cycle:

- the one-step program-counter advance during fetch;
- flags holding in every cycle that does not write the accumulator;
- the halt state persisting with a frozen program counter;
- data-memory read and write never overlapping.

Only the bench's program runs can show the rest. These include the arithmetic results and flag values over a sweep of operand pairs and all four ALU opcodes. They also include branch outcomes for every condition against negative, zero and positive accumulator values, the treatment of unrecognised opcodes, and the exact cycle count of each instruction class.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    // Opcode byte values
    localparam logic [7:0] OPC_LOAD  = 8'h01;
    localparam logic [7:0] OPC_STORE = 8'h02;
    localparam logic [7:0] OPC_ADD   = 8'h10;
    localparam logic [7:0] OPC_SUB   = 8'h11;
    localparam logic [7:0] OPC_AND   = 8'h12;
    localparam logic [7:0] OPC_OR    = 8'h13;
    localparam logic [7:0] OPC_JMP   = 8'h20;
    localparam logic [7:0] OPC_JZ    = 8'h21;
    localparam logic [7:0] OPC_JN    = 8'h22;
    localparam logic [7:0] OPC_HALT  = 8'hFF;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_FETCH_OP,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_DECODE,
        ST_MEM_LOAD,
        ST_MEM_STORE,
        ST_REG_OP,
        ST_BR_TAKEN,
        ST_BR_SKIP,
        ST_HALT
    } state_t;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_op_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              neg,
    output logic              zero
);

    localparam int unsigned MSB = DATA_W - 1;

    always_comb begin
        unique case (op)
            ALU_PASS: y = b;
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            default:  y = b;
        endcase
    end

    assign neg  = y[MSB];
    assign zero = (y == '0);

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int unsigned INSTR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] opcode,
    input  logic               flag_n,
    input  logic               flag_z,
    output logic               clear,
    output logic               ir_we,
    output logic               hi_we,
    output logic               lo_we,
    output logic               pc_inc,
    output logic               pc_load,
    output logic               ac_we,
    output logic               flag_we,
    output alu_op_t            alu_op,
    output logic               imem_rd,
    output logic               dmem_rd,
    output logic               dmem_wr,
    output logic               halted
);

    state_t state, state_nx;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:     state_nx = ST_FETCH_OP;
            ST_FETCH_OP: state_nx = ST_FETCH_HI;
            ST_FETCH_HI: state_nx = ST_FETCH_LO;
            ST_FETCH_LO: state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (opcode)
                    OPC_LOAD:  state_nx = ST_MEM_LOAD;
                    OPC_STORE: state_nx = ST_MEM_STORE;
                    OPC_ADD, OPC_SUB, OPC_AND, OPC_OR:
                               state_nx = ST_REG_OP;
                    OPC_JMP:   state_nx = ST_BR_TAKEN;
                    OPC_JZ:    state_nx = flag_z ? ST_BR_TAKEN : ST_BR_SKIP;
                    OPC_JN:    state_nx = flag_n ? ST_BR_TAKEN : ST_BR_SKIP;
                    OPC_HALT:  state_nx = ST_HALT;
                    default:   state_nx = ST_FETCH_OP;
                endcase
            end
            ST_MEM_LOAD, ST_MEM_STORE, ST_REG_OP,
            ST_BR_TAKEN, ST_BR_SKIP:
                state_nx = ST_FETCH_OP;
            ST_HALT:     state_nx = ST_HALT;
            default:     state_nx = ST_INIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_INIT;
        else     state <= state_nx;
    end

    // Output decode (register-transfer enables)
    always_comb begin
        clear   = 1'b0;
        ir_we   = 1'b0;
        hi_we   = 1'b0;
        lo_we   = 1'b0;
        pc_inc  = 1'b0;
        pc_load = 1'b0;
        ac_we   = 1'b0;
        flag_we = 1'b0;
        alu_op  = ALU_PASS;
        imem_rd = 1'b0;
        dmem_rd = 1'b0;
        dmem_wr = 1'b0;
        halted  = 1'b0;
        unique case (state)
            ST_INIT:     clear = 1'b1;
            ST_FETCH_OP: begin imem_rd = 1'b1; ir_we = 1'b1; pc_inc = 1'b1; end
            ST_FETCH_HI: begin imem_rd = 1'b1; hi_we = 1'b1; pc_inc = 1'b1; end
            ST_FETCH_LO: begin imem_rd = 1'b1; lo_we = 1'b1; pc_inc = 1'b1; end
            ST_DECODE:   ;
            ST_MEM_LOAD: begin
                dmem_rd = 1'b1;
                ac_we   = 1'b1;
                flag_we = 1'b1;
                alu_op  = ALU_PASS;
            end
            ST_MEM_STORE: dmem_wr = 1'b1;
            ST_REG_OP: begin
                dmem_rd = 1'b1;
                ac_we   = 1'b1;
                flag_we = 1'b1;
                unique case (opcode)
                    OPC_ADD: alu_op = ALU_ADD;
                    OPC_SUB: alu_op = ALU_SUB;
                    OPC_AND: alu_op = ALU_AND;
                    OPC_OR:  alu_op = ALU_OR;
                    default: alu_op = ALU_PASS;
                endcase
            end
            ST_BR_TAKEN: pc_load = 1'b1;
            ST_BR_SKIP:  ;
            ST_HALT:     halted = 1'b1;
            default:     ;
        endcase
    end

    // R10: data port never reads and writes together
    assert_mem_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr));

    // R9: once stopped, stays stopped until reset
    assert_halt_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> (state == ST_HALT));

endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned INSTR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               ir_we,
    input  logic               hi_we,
    input  logic               lo_we,
    input  logic               pc_inc,
    input  logic               pc_load,
    input  logic               ac_we,
    input  logic               flag_we,
    input  logic [INSTR_W-1:0] ibyte,
    input  logic [DATA_W-1:0]  result,
    input  logic               res_n,
    input  logic               res_z,
    output logic [ADDR_W-1:0]  pc,
    output logic [INSTR_W-1:0] ir,
    output logic [ADDR_W-1:0]  opaddr,
    output logic [DATA_W-1:0]  ac,
    output logic               flag_n,
    output logic               flag_z
);

    localparam int unsigned HALF = ADDR_W / 2;

    logic [HALF-1:0] addr_hi, addr_lo;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pc      <= '0;
            ir      <= '0;
            addr_hi <= '0;
            addr_lo <= '0;
            ac      <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
        end else begin
            if (ir_we) ir      <= ibyte;
            if (hi_we) addr_hi <= HALF'(ibyte);
            if (lo_we) addr_lo <= HALF'(ibyte);
            if (pc_load)     pc <= opaddr;
            else if (pc_inc) pc <= pc + 1'b1;
            if (ac_we) ac <= result;
            if (flag_we) begin
                flag_n <= res_n;
                flag_z <= res_z;
            end
        end
    end

    assign opaddr = {addr_hi, addr_lo};

    // R2: each fetch cycle steps the program counter by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !pc_load && !clear) |=> (pc == $past(pc) + 1'b1));

    // R5 / R7: flags move only on a flag-writing cycle
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!flag_we && !clear) |=> $stable({flag_n, flag_z}));

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned INSTR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  imem_addr,
    output logic               imem_rd,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0]  dmem_addr,
    output logic               dmem_rd,
    output logic               dmem_wr,
    output logic [DATA_W-1:0]  dmem_wdata,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [INSTR_W-1:0] ir_q,
    output logic [DATA_W-1:0]  ac_q,
    output logic               flag_n,
    output logic               flag_z,
    output logic               halted
);

    logic            clear, ir_we, hi_we, lo_we, pc_inc, pc_load;
    logic            ac_we, flag_we, res_n, res_z;
    alu_op_t         alu_op;
    logic [DATA_W-1:0] alu_y;
    logic [ADDR_W-1:0] opaddr;

    acc_ctrl #(.INSTR_W(INSTR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .opcode  (ir_q),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .clear   (clear),
        .ir_we   (ir_we),
        .hi_we   (hi_we),
        .lo_we   (lo_we),
        .pc_inc  (pc_inc),
        .pc_load (pc_load),
        .ac_we   (ac_we),
        .flag_we (flag_we),
        .alu_op  (alu_op),
        .imem_rd (imem_rd),
        .dmem_rd (dmem_rd),
        .dmem_wr (dmem_wr),
        .halted  (halted)
    );

    acc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .ir_we   (ir_we),
        .hi_we   (hi_we),
        .lo_we   (lo_we),
        .pc_inc  (pc_inc),
        .pc_load (pc_load),
        .ac_we   (ac_we),
        .flag_we (flag_we),
        .ibyte   (imem_rdata),
        .result  (alu_y),
        .res_n   (res_n),
        .res_z   (res_z),
        .pc      (pc_q),
        .ir      (ir_q),
        .opaddr  (opaddr),
        .ac      (ac_q),
        .flag_n  (flag_n),
        .flag_z  (flag_z)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op   (alu_op),
        .a    (ac_q),
        .b    (dmem_rdata),
        .y    (alu_y),
        .neg  (res_n),
        .zero (res_z)
    );

    assign imem_addr  = pc_q;
    assign dmem_addr  = opaddr;
    assign dmem_wdata = ac_q;

    // R9: program counter frozen while stopped
    assert_halt_pc_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc_q));

endmodule

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata, pc_q, ac_q;
    logic [7:0]  imem_rdata, ir_q;
    logic        imem_rd, dmem_rd, dmem_wr, flag_n, flag_z, halted;

    logic [7:0]  imem [0:255];
    logic [15:0] dmem [0:255];
    logic        pl_en = 1'b0;
    logic [7:0]  pl_addr = 8'h0;
    logic [15:0] pl_data = 16'h0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rd(imem_rd), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .pc_q(pc_q), .ir_q(ir_q), .ac_q(ac_q),
        .flag_n(flag_n), .flag_z(flag_z), .halted(halted)
    );

    assign imem_rdata = imem[imem_addr[7:0]];
    assign dmem_rdata = dmem[dmem_addr[7:0]];

    always @(posedge clk) begin
        if (pl_en)        dmem[pl_addr] <= pl_data;
        else if (dmem_wr) dmem[dmem_addr[7:0]] <= dmem_wdata;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) imem[i] = 8'hFF;
    endtask

    task automatic put(input int at, input logic [7:0] op, input logic [15:0] a);
        imem[at]     = op;
        imem[at + 1] = a[15:8];
        imem[at + 2] = a[7:0];
    endtask

    task automatic preload(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    // Runs the loaded program from reset; returns cycles to halt, writes seen
    task automatic run(output int cycles, output int writes, output int overlap);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cycles = 0; writes = 0; overlap = 0;
        while (!halted && cycles < 400) begin
            @(posedge clk);
            #1;
            cycles++;
            if (dmem_wr) writes++;
            if (dmem_wr && dmem_rd) overlap++;
        end
    endtask

    logic [15:0] vals [0:7];

    initial begin
        int cyc, wr, ov;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002;
        vals[3] = 16'h7FFF; vals[4] = 16'h8000; vals[5] = 16'hFFFF;
        vals[6] = 16'h1234; vals[7] = 16'hF0F0;
        clear_prog();
        for (int i = 0; i < 256; i++) dmem[i] = 16'h0;

        // R1: reset state and the initialise cycle
        repeat (3) @(posedge clk);
        #1;
        check("R1", "pc in reset", 32'(pc_q), 32'h0);
        check("R1", "ac in reset", 32'(ac_q), 32'h0);
        check("R1", "ir in reset", 32'(ir_q), 32'h0);
        check("R1", "flags in reset", {30'd0, flag_n, flag_z}, 32'h0);
        check("R1", "mem strobes in reset", {29'd0, imem_rd, dmem_rd, dmem_wr}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "init cycle imem_rd", 32'(imem_rd), 32'h0);
        @(posedge clk);
        #1;
        check("R1", "first fetch strobe", 32'(imem_rd), 32'h1);
        check("R1", "first fetch address", 32'(imem_addr), 32'h0);

        // R4: load sweep, then halt at 3
        for (int i = 0; i < 8; i++) begin
            clear_prog();
            put(0, 8'h01, 16'h0010);
            preload(8'h10, vals[i]);
            run(cyc, wr, ov);
            check("R4", "load ac", 32'(ac_q), 32'(vals[i]));
            check("R4", "load N", 32'(flag_n), 32'(vals[i][15]));
            check("R4", "load Z", 32'(flag_z), 32'(vals[i] == 16'h0));
            check("R3", "load+halt cycles", 32'(cyc), 32'd10);
            check("R2", "pc at halt", 32'(pc_q), 32'd6);
            check("R2", "ir at halt", 32'(ir_q), 32'hFF);
        end

        // R6 / R5: all ALU ops over all operand pairs, result stored
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [15:0] a, b, r;
                    a = vals[i]; b = vals[j];
                    case (op)
                        0: r = a + b;
                        1: r = a - b;
                        2: r = a & b;
                        default: r = a | b;
                    endcase
                    clear_prog();
                    put(0, 8'h01, 16'h0010);
                    put(3, 8'h10 + 8'(op), 16'h0011);
                    put(6, 8'h02, 16'h0020);
                    preload(8'h10, a);
                    preload(8'h11, b);
                    preload(8'h20, 16'hDEAD);
                    run(cyc, wr, ov);
                    check("R6", "alu ac", 32'(ac_q), 32'(r));
                    check("R6", "alu N after store (R5)", 32'(flag_n), 32'(r[15]));
                    check("R6", "alu Z after store (R5)", 32'(flag_z), 32'(r == 16'h0));
                    check("R5", "stored word", 32'(dmem[8'h20]), 32'(r));
                    check("R5", "write count", 32'(wr), 32'd1);
                    check("R10", "rd/wr overlap", 32'(ov), 32'd0);
                    check("R3", "alu program cycles", 32'(cyc), 32'd20);
                end
            end
        end

        // R7: branch conditions against each loaded value
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 8; i++) begin
                logic take;
                take = (k == 0) ? 1'b1 : (k == 1) ? (vals[i] == 16'h0) : vals[i][15];
                clear_prog();
                put(0, 8'h01, 16'h0010);
                put(3, 8'h20 + 8'(k), 16'h000C);
                preload(8'h10, vals[i]);
                run(cyc, wr, ov);
                check("R7", "branch target pc", 32'(pc_q), take ? 32'h0F : 32'h09);
                check("R7", "branch keeps ac", 32'(ac_q), 32'(vals[i]));
                check("R7", "branch keeps N", 32'(flag_n), 32'(vals[i][15]));
                check("R7", "branch keeps Z", 32'(flag_z), 32'(vals[i] == 16'h0));
                check("R3", "branch program cycles", 32'(cyc), 32'd15);
            end
        end

        // R8: unrecognised opcodes behave as no-ops
        for (int u = 0; u < 7; u++) begin
            logic [7:0] unk;
            case (u)
                0: unk = 8'h00; 1: unk = 8'h03; 2: unk = 8'h14; 3: unk = 8'h23;
                4: unk = 8'h7F; 5: unk = 8'h80; default: unk = 8'hFE;
            endcase
            clear_prog();
            put(0, 8'h01, 16'h0010);
            put(3, unk, 16'h0000);
            put(6, 8'h02, 16'h0020);
            preload(8'h10, 16'h8000);
            preload(8'h20, 16'h0000);
            run(cyc, wr, ov);
            check("R8", "no-op keeps ac", 32'(ac_q), 32'h8000);
            check("R8", "no-op keeps N", 32'(flag_n), 32'h1);
            check("R8", "later store done", 32'(dmem[8'h20]), 32'h8000);
            check("R8", "pc past all", 32'(pc_q), 32'd12);
            check("R3", "no-op program cycles", 32'(cyc), 32'd19);
        end

        // R9: stopped state holds with no memory traffic
        begin
            int moved = 0;
            int traffic = 0;
            int dropped = 0;
            logic [15:0] hold_pc;
            hold_pc = pc_q;
            repeat (30) begin
                @(posedge clk);
                #1;
                if (pc_q !== hold_pc) moved++;
                if (imem_rd || dmem_rd || dmem_wr) traffic++;
                if (!halted) dropped++;
            end
            check("R9", "pc moved while halted", 32'(moved), 32'd0);
            check("R9", "memory traffic while halted", 32'(traffic), 32'd0);
            check("R9", "halted dropped", 32'(dropped), 32'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule